// File: doc/BRIEF.md
# Bounded Up/Down Event Counter with Sticky Status

This block counts events up or down between a lower and an upper limit that software sets. Each count step happens on a strobe, and only while the gate input is high. When a step would carry the value past a limit, the count wraps to the opposite limit and a flag is raised. A synchronization request loads a preset value into the counter on the next step.

The block keeps a small status word. The direction bit and the gate-running bit are live and follow their inputs. The zero-crossing, underflow, overflow and synchronization flags are sticky: they stay set until the host pulses one shared clear input, which clears all four. If an event and the clear arrive in the same cycle, the event wins.

Top module: `bounded_event_counter`

## Requirements
- R1: While rst_n is low, the count is 0 and all four sticky flags are 0. The count, flags and pending synchronization are also 0 after release, until the first step.
- R2: A step happens only on a clock edge where cnt_pulse and gate_en are both 1. On a plain step, the count rises by 1 if dir_up is 1 and falls by 1 if dir_up is 0. With no step, the count holds.
- R3: sts_up equals dir_up and sts_gate equals gate_en, combinationally, at every moment.
- R4: An up step taken while count >= lim_hi (signed) loads lim_lo instead of adding 1. The overflow flag reads 1 from the following cycle.
- R5: A down step taken while count <= lim_lo (signed) loads lim_hi instead of subtracting 1. The underflow flag reads 1 from the following cycle.
- R6: When free_dir is 1, a plain up step from -1 to 0, or a plain down step from 0 to -1, sets the zero-crossing flag. When free_dir is 0, these steps leave the flag unchanged.
- R7: A sync_req pulse is remembered. The first step taken while a request is pending, or on the same edge as the request, loads load_val in place of counting, sets the sync flag and clears the pending request. No limit check applies to that step.
- R8: All four sticky flags hold their value until a cycle with sts_clr = 1, which clears every flag that has no new event on that edge.
- R9: An event on the same edge as sts_clr leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_pulse | input | 1 | Count strobe, one step per cycle high |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| gate_en | input | 1 | Enables counting |
| free_dir | input | 1 | 1 = counting with no main direction, which enables zero-crossing detection |
| sync_req | input | 1 | Requests a load of load_val on the next step |
| sts_clr | input | 1 | Clears all sticky flags |
| lim_lo | input | W | Lower count limit, signed |
| lim_hi | input | W | Upper count limit, signed |
| load_val | input | W | Value loaded by synchronization, signed |
| count | output | W | Current count, signed |
| sts_up | output | 1 | Live direction status |
| sts_gate | output | 1 | Live gate-running status |
| flg_zero | output | 1 | Sticky zero-crossing flag |
| flg_udf | output | 1 | Sticky underflow flag |
| flg_ovf | output | 1 | Sticky overflow flag |
| flg_sync | output | 1 | Sticky synchronization-done flag |

## Verification
A wrong count shows at the count port on the cycle after the faulty step. The error then carries into every later value, so one compare per cycle against a model finds it at once. A wrong wrap decision or a lost pending request gives a wrong count, and also a wrong flag, on the next cycle. A flag that clears early or fails to set is caught the next cycle, because the flags are compared every cycle. Random short limit windows make wraps, zero crossings and clear-versus-event collisions frequent.

// File: rtl/bounded_event_counter.sv
module bounded_event_counter #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_pulse,
  input  logic                dir_up,
  input  logic                gate_en,
  input  logic                free_dir,
  input  logic                sync_req,
  input  logic                sts_clr,
  input  logic signed [W-1:0] lim_lo,
  input  logic signed [W-1:0] lim_hi,
  input  logic signed [W-1:0] load_val,
  output logic signed [W-1:0] count,
  output logic                sts_up,
  output logic                sts_gate,
  output logic                flg_zero,
  output logic                flg_udf,
  output logic                flg_ovf,
  output logic                flg_sync
);

  localparam logic signed [W-1:0] MINUS1 = '1;

  logic step, load, at_hi, at_lo, pend;
  logic ev_ovf, ev_udf, ev_zero;
  logic signed [W-1:0] nxt;

  assign sts_up   = dir_up;
  assign sts_gate = gate_en;

  assign step  = gate_en & cnt_pulse;
  assign load  = step & (pend | sync_req);
  assign at_hi = count >= lim_hi;
  assign at_lo = count <= lim_lo;

  assign ev_ovf  = step & ~load & dir_up & at_hi;
  assign ev_udf  = step & ~load & ~dir_up & at_lo;
  assign ev_zero = step & ~load & free_dir &
                   ((dir_up & ~at_hi & (count == MINUS1)) |
                    (~dir_up & ~at_lo & (count == '0)));

  always_comb begin
    nxt = count;
    if (load)        nxt = load_val;
    else if (ev_ovf) nxt = lim_lo;
    else if (ev_udf) nxt = lim_hi;
    else if (step)   nxt = dir_up ? count + 1'b1 : count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      pend     <= 1'b0;
      flg_zero <= 1'b0;
      flg_udf  <= 1'b0;
      flg_ovf  <= 1'b0;
      flg_sync <= 1'b0;
    end else begin
      count    <= nxt;
      pend     <= ~load & (pend | sync_req);
      flg_zero <= ev_zero | (flg_zero & ~sts_clr);
      flg_udf  <= ev_udf  | (flg_udf  & ~sts_clr);
      flg_ovf  <= ev_ovf  | (flg_ovf  & ~sts_clr);
      flg_sync <= load    | (flg_sync & ~sts_clr);
    end
  end

  // R2
  hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_en && cnt_pulse) |=> $stable(count));

  // R4
  wrap_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_ovf) |-> count == $past(lim_lo));

  // R5
  wrap_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_udf) |-> count == $past(lim_hi));

  // R7
  sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_sync) |-> count == $past(load_val));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_ovf && !sts_clr |=> flg_ovf);

  // R8
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flg_zero && !sts_clr |=> flg_zero);

  // R2
  flag_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_udf) |-> $past(gate_en && cnt_pulse));

endmodule

// File: tb/tb_bounded_event_counter.sv
module tb_bounded_event_counter;
  localparam int W = 32;
  logic clk = 0, rst_n = 0;
  logic cnt_pulse = 0, dir_up = 0, gate_en = 0, free_dir = 0, sync_req = 0, sts_clr = 0;
  logic signed [W-1:0] lim_lo = -4, lim_hi = 4, load_val = 0;
  logic signed [W-1:0] count;
  logic sts_up, sts_gate, flg_zero, flg_udf, flg_ovf, flg_sync;

  int n_chk = 0, n_bad = 0;
  logic signed [W-1:0] mc;
  logic mz, mu, mo, ms, mp;

  always #4 clk = ~clk;

  bounded_event_counter #(.W(W)) dut (.*);

  task automatic chk(string req, logic signed [W-1:0] got, logic signed [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic sticky(logic ev, logic f, logic clr);
    return ev | (f & ~clr);
  endfunction

  task automatic model_step();
    logic st, ld, eo, eu, ez;
    logic signed [W-1:0] nc;
    st = gate_en & cnt_pulse;
    ld = st & (mp | sync_req);
    eo = 0; eu = 0; ez = 0; nc = mc;
    if (ld) nc = load_val;
    else if (st && dir_up) begin
      if (mc >= lim_hi) begin nc = lim_lo; eo = 1; end
      else begin nc = mc + 1; ez = free_dir && mc == -1; end
    end else if (st) begin
      if (mc <= lim_lo) begin nc = lim_hi; eu = 1; end
      else begin nc = mc - 1; ez = free_dir && mc == 0; end
    end
    mc = nc;
    mp = ~ld & (mp | sync_req);
    mz = sticky(ez, mz, sts_clr);
    mu = sticky(eu, mu, sts_clr);
    mo = sticky(eo, mo, sts_clr);
    ms = sticky(ld, ms, sts_clr);
  endtask

  task automatic compare_all();
    chk("R2 count", count, mc);
    chk("R6 flg_zero", W'(flg_zero), W'(mz));
    chk("R5 flg_udf", W'(flg_udf), W'(mu));
    chk("R4 flg_ovf", W'(flg_ovf), W'(mo));
    chk("R7 flg_sync", W'(flg_sync), W'(ms));
  endtask

  task automatic cyc(logic g, logic p, logic u, logic s, logic c, logic f);
    gate_en = g; cnt_pulse = p; dir_up = u; sync_req = s; sts_clr = c; free_dir = f;
    #1;
    chk("R3 sts_up", W'(sts_up), W'(u));
    chk("R3 sts_gate", W'(sts_gate), W'(g));
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 flags", W'({flg_zero, flg_udf, flg_ovf, flg_sync}), 0);
    rst_n = 1;
    mc = 0; mz = 0; mu = 0; mo = 0; ms = 0; mp = 0;
    @(negedge clk);
    compare_all();

    // R2 gate low: no change
    cyc(0, 1, 1, 0, 0, 0);
    chk("R2 gate off hold", count, 0);
    cyc(1, 1, 1, 0, 0, 0);
    chk("R2 up step", count, 1);
    // R7 sync pending then loaded on next step
    load_val = 4;
    cyc(0, 0, 1, 1, 0, 0);
    chk("R7 no load without step", count, 1);
    cyc(1, 1, 1, 0, 0, 0);
    chk("R7 load_val", count, 4);
    chk("R7 flag", W'(flg_sync), 1);
    // R4 overflow wraps to lim_lo
    cyc(1, 1, 1, 0, 0, 0);
    chk("R4 wrap", count, -4);
    chk("R4 flag", W'(flg_ovf), 1);
    // R5 underflow wraps to lim_hi, event with clear: R9
    cyc(1, 1, 0, 0, 1, 0);
    chk("R5 wrap", count, 4);
    chk("R9 udf kept", W'(flg_udf), 1);
    chk("R8 ovf cleared", W'(flg_ovf), 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk("R8 all cleared", W'({flg_zero, flg_udf, flg_ovf, flg_sync}), 0);
    // R6 zero crossing only with free_dir
    load_val = -1;
    cyc(1, 1, 1, 1, 0, 0);
    cyc(1, 1, 1, 0, 0, 0);
    chk("R6 no flag when free_dir=0", W'(flg_zero), 0);
    cyc(1, 1, 0, 0, 0, 1);
    chk("R6 down cross", count, -1);
    chk("R6 flag set", W'(flg_zero), 1);

    for (int blk = 0; blk < 20; blk++) begin
      lim_lo = -$signed(W'($urandom_range(0, 5)));
      lim_hi = $signed(W'($urandom_range(0, 5)));
      for (int i = 0; i < 150; i++) begin
        load_val = $signed(W'($urandom_range(0, 12))) - 6;
        cyc($urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 15) == 0, $urandom_range(0, 9) == 0, $urandom_range(0, 3) != 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule